// File: doc/BRIEF.md
# Secondary Core Power-Down Sequencer

This block turns off one of three secondary processor cores, or all three in turn. Each core has a 7-bit power control vector and an L1 cache power-down request with a matching acknowledge. A start pulse carries either a core number or a batch flag. The block then takes each core through a fixed order of steps:

1. Unlock the power controller with a keyed configuration write.
2. Isolate the core's outputs and its SRAM.
3. Ask the L1 cache to power down, and wait for it to agree.
4. Hold the core in reset, stop its clock, and open its two power switches.

The core is off only when the primary and the secondary switch status both report it unpowered.

Every step takes one clock cycle. Waiting for the acknowledge and waiting for the status have no time limit. A caller sees `busy` while a request is in progress and a one-cycle `done` when it finishes. A request that names no valid core finishes at once and changes nothing.

Top module: `core_pdn_seq`

## Requirements
- R1: After reset every control vector reads 7'h4D, which is powered and non-isolated: bit 0 reset_n=1, bit 1 iso=0, bit 2 main switch=1, bit 3 second switch=1, bit 4 clock off=0, bit 5 SRAM clock isolate=0, bit 6 SRAM isolate_n=1. After reset `l1_req`, `busy`, `done` and `key_wr` are 0 and `key_word` is 0.
- R2: In the cycle after a start is accepted, and again before each core of a batch, `key_wr` pulses for one cycle. During that cycle `key_word` is {16-bit key, 15'b0, 1'b1}. The pulse comes before any change to that core's vector.
- R3: Before the acknowledge stage the core's vector changes once per cycle: 4D, then 4F (iso set), then 6F (SRAM clock isolate set), then 2F (SRAM isolate_n cleared). In the cycle after that, the core's `l1_req` bit rises and stays high.
- R4: While the selected core's `l1_ack` bit is low, its vector stays at 2F and `busy` stays high, with no timeout.
- R5: After the acknowledge the vector changes once per cycle: 2E (reset_n cleared), then 3E (clock off set), then 3A (main switch cleared), then 32 (second switch cleared).
- R6: `done` stays low while either `sta_pri` or `sta_sec` has the core's bit set; bit k-1 belongs to core k. `done` rises in the cycle after both bits read 0.
- R7: A batch start turns off cores 1, 2 and 3 in that order and sends one key write per core.
- R8: A non-batch start whose `core_sel` is outside 1..3 makes no key write and changes no vector or request. It pulses `done` in the next cycle and leaves `busy` low.
- R9: `busy` is high from the cycle after an accepted start until the cycle in which `done` rises. `done` lasts exactly one cycle.
- R10: A start that arrives while `busy` is high is ignored.
- R11: The vectors and requests of cores that are not selected do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | One-cycle request pulse |
| batch | input | 1 | With start: turn off cores 1, 2, 3 in order |
| core_sel | input | 2 | With start and no batch: core number, valid values 1 to 3 |
| l1_ack | input | 3 | L1 power-down acknowledge, bit k-1 for core k |
| sta_pri | input | 3 | Primary switch status, 1 = powered, bit k-1 for core k |
| sta_sec | input | 3 | Secondary switch status, 1 = powered, bit k-1 for core k |
| ctl_vec | output | 21 | Control vectors, core k at bits [7k-1 : 7k-7] |
| l1_req | output | 3 | L1 power-down request, bit k-1 for core k |
| key_wr | output | 1 | Configuration-enable write strobe |
| key_word | output | 32 | Configuration-enable word, valid with key_wr |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest state to reach is the dropped start: a second start that arrives in the middle of a request. The bench first parks core 1 in its acknowledge wait by holding `l1_ack` low. It then issues a start for core 3 and completes core 1. After that it checks three things: core 3's vector and request never moved, and only one `done` appeared. The status wait is also tested in two steps. The bench clears the primary status bit and confirms that `done` stays low, then clears the secondary bit and expects `done`. For the batch run, a responder in the bench answers requests from the live control bits. This lets the bench check the order in which the cores are served and the key write that comes before each one.

// File: rtl/core_pdn_pkg.sv
package core_pdn_pkg;

  localparam int CTL_W = 7;

  // Control vector bit positions
  localparam int B_RSTN   = 0;
  localparam int B_ISO    = 1;
  localparam int B_PON    = 2;
  localparam int B_PON2   = 3;
  localparam int B_CKOFF  = 4;
  localparam int B_SCKISO = 5;
  localparam int B_SISON  = 6;

  // Powered, released, non-isolated
  localparam logic [CTL_W-1:0] CTL_RESET = 7'h4D;

  typedef enum logic [3:0] {
    ST_IDLE, ST_KEY, ST_ISO, ST_SCKISO, ST_SISO, ST_L1,
    ST_WACK, ST_RST, ST_CKOFF, ST_POFF1, ST_POFF2, ST_WSTA
  } seq_state_e;

  typedef enum logic [3:0] {
    OP_NONE, OP_ISO, OP_SCKISO, OP_SISO, OP_L1REQ,
    OP_RST, OP_CKOFF, OP_POFF1, OP_POFF2
  } step_op_e;

endpackage

// File: rtl/core_pdn_fsm.sv
module core_pdn_fsm
  import core_pdn_pkg::*;
#(
  parameter int NUM_CORES = 3,
  parameter int SEL_W     = 2,
  parameter int IDX_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             batch,
  input  logic [SEL_W-1:0] core_sel,
  input  logic             ack_cur,
  input  logic             off_cur,
  output logic [IDX_W-1:0] cur_idx,
  output step_op_e         step,
  output logic             key_wr,
  output logic             busy,
  output logic             done
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CORES - 1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] cur_q, cur_d;
  logic             batch_q, batch_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic             sel_ok;

  assign sel_ok = (core_sel != '0) && (core_sel <= SEL_W'(NUM_CORES));

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    batch_d = batch_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (batch) begin
            cur_d   = '0;
            batch_d = 1'b1;
            busy_d  = 1'b1;
            state_d = ST_KEY;
          end else if (sel_ok) begin
            cur_d   = IDX_W'(core_sel - SEL_W'(1));
            batch_d = 1'b0;
            busy_d  = 1'b1;
            state_d = ST_KEY;
          end else begin
            done_d  = 1'b1;
          end
        end
      end
      ST_KEY:    state_d = ST_ISO;
      ST_ISO:    state_d = ST_SCKISO;
      ST_SCKISO: state_d = ST_SISO;
      ST_SISO:   state_d = ST_L1;
      ST_L1:     state_d = ST_WACK;
      ST_WACK:   if (ack_cur) state_d = ST_RST;
      ST_RST:    state_d = ST_CKOFF;
      ST_CKOFF:  state_d = ST_POFF1;
      ST_POFF1:  state_d = ST_POFF2;
      ST_POFF2:  state_d = ST_WSTA;
      ST_WSTA: begin
        if (off_cur) begin
          if (batch_q && (cur_q != LAST_IDX)) begin
            cur_d   = cur_q + IDX_W'(1);
            state_d = ST_KEY;
          end else begin
            batch_d = 1'b0;
            busy_d  = 1'b0;
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      default:   state_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      batch_q <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      batch_q <= batch_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
    end
  end

  // Step decode
  always_comb begin
    unique case (state_q)
      ST_ISO:    step = OP_ISO;
      ST_SCKISO: step = OP_SCKISO;
      ST_SISO:   step = OP_SISO;
      ST_L1:     step = OP_L1REQ;
      ST_RST:    step = OP_RST;
      ST_CKOFF:  step = OP_CKOFF;
      ST_POFF1:  step = OP_POFF1;
      ST_POFF2:  step = OP_POFF2;
      default:   step = OP_NONE;
    endcase
  end

  assign cur_idx = cur_q;
  assign key_wr  = (state_q == ST_KEY);
  assign busy    = busy_q;
  assign done    = done_q;

endmodule

// File: rtl/core_pdn_ctlbank.sv
module core_pdn_ctlbank
  import core_pdn_pkg::*;
#(
  parameter int NUM_CORES = 3,
  parameter int IDX_W     = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [IDX_W-1:0]           cur_idx,
  input  step_op_e                   step,
  output logic [NUM_CORES*CTL_W-1:0] ctl_vec,
  output logic [NUM_CORES-1:0]       l1_req
);

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    logic [CTL_W-1:0] vec_q;
    logic             req_q;
    logic             en;

    assign en = (cur_idx == IDX_W'(g)) && (step != OP_NONE);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vec_q <= CTL_RESET;
        req_q <= 1'b0;
      end else if (en) begin
        unique case (step)
          OP_ISO:    vec_q[B_ISO]    <= 1'b1;
          OP_SCKISO: vec_q[B_SCKISO] <= 1'b1;
          OP_SISO:   vec_q[B_SISON]  <= 1'b0;
          OP_L1REQ:  req_q           <= 1'b1;
          OP_RST:    vec_q[B_RSTN]   <= 1'b0;
          OP_CKOFF:  vec_q[B_CKOFF]  <= 1'b1;
          OP_POFF1:  vec_q[B_PON]    <= 1'b0;
          OP_POFF2:  vec_q[B_PON2]   <= 1'b0;
          default:   ;
        endcase
      end
    end

    assign ctl_vec[g*CTL_W +: CTL_W] = vec_q;
    assign l1_req[g]                 = req_q;
  end

endmodule

// File: rtl/core_pdn_seq.sv
module core_pdn_seq
  import core_pdn_pkg::*;
#(
  parameter int              NUM_CORES = 3,
  parameter int              KEY_W     = 16,
  parameter int              WORD_W    = 32,
  parameter logic [KEY_W-1:0] CFG_KEY  = 16'h0B16,
  localparam int             SEL_W     = $clog2(NUM_CORES + 1),
  localparam int             IDX_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int             VEC_W     = NUM_CORES * CTL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 batch,
  input  logic [SEL_W-1:0]     core_sel,
  input  logic [NUM_CORES-1:0] l1_ack,
  input  logic [NUM_CORES-1:0] sta_pri,
  input  logic [NUM_CORES-1:0] sta_sec,
  output logic [VEC_W-1:0]     ctl_vec,
  output logic [NUM_CORES-1:0] l1_req,
  output logic                 key_wr,
  output logic [WORD_W-1:0]    key_word,
  output logic                 busy,
  output logic                 done
);

  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  logic [IDX_W-1:0] cur_idx;
  step_op_e         step;
  logic             ack_cur;
  logic             off_cur;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  // Pick the selected core's acknowledge and status bits
  always_comb begin
    ack_cur = 1'b0;
    off_cur = 1'b0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (cur_idx == IDX_W'(i)) begin
        ack_cur = l1_ack[i];
        off_cur = !sta_pri[i] && !sta_sec[i];
      end
    end
  end

  core_pdn_fsm #(
    .NUM_CORES (NUM_CORES),
    .SEL_W     (SEL_W),
    .IDX_W     (IDX_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .start    (start),
    .batch    (batch),
    .core_sel (core_sel),
    .ack_cur  (ack_cur),
    .off_cur  (off_cur),
    .cur_idx  (cur_idx),
    .step     (step),
    .key_wr   (key_wr),
    .busy     (busy),
    .done     (done)
  );

  core_pdn_ctlbank #(
    .NUM_CORES (NUM_CORES),
    .IDX_W     (IDX_W)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .cur_idx (cur_idx),
    .step    (step),
    .ctl_vec (ctl_vec),
    .l1_req  (l1_req)
  );

  assign key_word = key_wr ? {CFG_KEY, {(WORD_W-KEY_W-1){1'b0}}, 1'b1} : '0;

endmodule

// File: rtl/core_pdn_chk.sv
module core_pdn_chk
  import core_pdn_pkg::*;
#(
  parameter int NUM_CORES = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_CORES*CTL_W-1:0] ctl_vec,
  input logic [NUM_CORES-1:0]       l1_req,
  input logic                       key_wr,
  input logic                       busy,
  input logic                       done
);

  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r2_key_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr |-> busy);

  a_r10_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(ctl_vec) && $stable(l1_req));

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    logic [CTL_W-1:0] v;
    assign v = ctl_vec[g*CTL_W +: CTL_W];

    a_r3_req_after_iso: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(l1_req[g]) |-> v[B_ISO] && v[B_SCKISO] && !v[B_SISON]);

    a_r4_rst_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      !l1_req[g] |-> v[B_RSTN]);

    a_r5_poff_after_ckoff: assert property (@(posedge clk) disable iff (!rst_n)
      !v[B_PON] |-> v[B_CKOFF] && !v[B_RSTN]);
  end

endmodule

bind core_pdn_seq core_pdn_chk #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ctl_vec (ctl_vec),
  .l1_req  (l1_req),
  .key_wr  (key_wr),
  .busy    (busy),
  .done    (done)
);

// File: tb/tb_core_pdn_seq.sv
module tb_core_pdn_seq;

  localparam logic [31:0] KEY_EXP = {16'h0B16, 15'b0, 1'b1};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, batch;
  logic [1:0]  core_sel;
  logic [2:0]  l1_ack, sta_pri, sta_sec;
  logic [20:0] ctl_vec;
  logic [2:0]  l1_req;
  logic        key_wr;
  logic [31:0] key_word;
  logic        busy, done;
  logic        auto_env;

  int ntests = 0;
  int nfail  = 0;
  int cycles = 0;

  core_pdn_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .batch(batch), .core_sel(core_sel),
    .l1_ack(l1_ack), .sta_pri(sta_pri), .sta_sec(sta_sec), .ctl_vec(ctl_vec),
    .l1_req(l1_req), .key_wr(key_wr), .key_word(key_word), .busy(busy), .done(done)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nfail++;
      ntests++;
      $display("FAIL R9 watchdog expired act=%0d exp<=100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  // Responder for batch runs: answers from the live control bits
  always @(negedge clk) begin
    if (auto_env) begin
      l1_ack = l1_req;
      for (int g = 0; g < 3; g++) begin
        sta_pri[g] = ctl_vec[g*7 + 2];
        sta_sec[g] = ctl_vec[g*7 + 3];
      end
    end
  end

  function automatic logic [6:0] cv(input int c);
    return ctl_vec[(c-1)*7 +: 7];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    auto_env = 1'b0;
    rst_n = 1'b0; start = 1'b0; batch = 1'b0; core_sel = '0;
    l1_ack = '0; sta_pri = '1; sta_sec = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic test_reset();
    do_reset();
    for (int c = 1; c <= 3; c++) chk(cv(c) == 7'h4D, "R1 reset vector", cv(c), 7'h4D);
    chk(l1_req == 0 && busy == 0 && done == 0 && key_wr == 0 && key_word == 0,
        "R1 reset outputs", {l1_req, busy, done, key_wr}, 0);
  endtask

  task automatic test_single();
    logic [6:0] seq_pre [4] = '{7'h4D, 7'h4F, 7'h6F, 7'h2F};
    logic [6:0] seq_post[4] = '{7'h2E, 7'h3E, 7'h3A, 7'h32};
    bit ok;
    do_reset();
    @(negedge clk); core_sel = 2; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(key_wr == 1 && key_word == KEY_EXP, "R2 key word", key_word, KEY_EXP);
    chk(busy == 1, "R9 busy after start", busy, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(cv(2) == seq_pre[i], "R3 pre-ack order", cv(2), seq_pre[i]);
      if (i == 0) chk(key_wr == 0, "R2 key one cycle", key_wr, 0);
    end
    chk(l1_req[1] == 0, "R3 req after sram iso", l1_req, 0);
    @(negedge clk);
    chk(l1_req == 3'b010, "R3 req raised", l1_req, 3'b010);
    ok = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (cv(2) != 7'h2F || !busy) ok = 0;
    end
    chk(ok, "R4 stall without ack", cv(2), 7'h2F);
    l1_ack[1] = 1'b1;
    @(negedge clk);
    chk(cv(2) == 7'h2F, "R4 ack sampled", cv(2), 7'h2F);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(cv(2) == seq_post[i], "R5 post-ack order", cv(2), seq_post[i]);
    end
    ok = 1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (done || !busy) ok = 0;
    end
    sta_pri[1] = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (done || !busy) ok = 0;
    end
    chk(ok, "R6 no done while a status is set", done, 0);
    sta_sec[1] = 1'b0;
    @(negedge clk);
    chk(done == 1 && busy == 0, "R6 done after both clear", {busy, done}, 2'b01);
    @(negedge clk);
    chk(done == 0, "R9 done one cycle", done, 0);
    chk(cv(1) == 7'h4D && cv(3) == 7'h4D && l1_req == 3'b010, "R11 others untouched",
        {cv(1), cv(3)}, {7'h4D, 7'h4D});
  endtask

  task automatic test_batch();
    int ord[3];
    int nord = 0;
    int keys = 0;
    int dones = 0;
    int key_at[3];
    logic [2:0] prev_req = '0;
    logic [6:0] prev_v[3] = '{7'h4D, 7'h4D, 7'h4D};
    bit seen[3] = '{0, 0, 0};
    do_reset();
    auto_env = 1'b1;
    @(negedge clk); batch = 1'b1; core_sel = 0; start = 1'b1;
    @(negedge clk); start = 1'b0; batch = 1'b0;
    for (int t = 0; t < 400; t++) begin
      if (key_wr) keys++;
      if (done) dones++;
      for (int g = 0; g < 3; g++) begin
        if (l1_req[g] && !prev_req[g] && nord < 3) begin
          ord[nord] = g + 1;
          nord++;
        end
        if (cv(g+1) != prev_v[g] && !seen[g]) begin
          seen[g] = 1;
          key_at[g] = keys;
        end
        prev_v[g] = cv(g+1);
      end
      prev_req = l1_req;
      @(negedge clk);
    end
    chk(nord == 3 && ord[0] == 1 && ord[1] == 2 && ord[2] == 3, "R7 batch order",
        {ord[0][7:0], ord[1][7:0], ord[2][7:0]}, 32'h010203);
    chk(keys == 3, "R7 one key per core", keys, 3);
    chk(key_at[0] == 1 && key_at[1] == 2 && key_at[2] == 3, "R2 key before each core",
        {key_at[0][7:0], key_at[1][7:0], key_at[2][7:0]}, 32'h010203);
    chk(dones == 1, "R9 single done for batch", dones, 1);
    for (int c = 1; c <= 3; c++) chk(cv(c) == 7'h32, "R7 all cores off", cv(c), 7'h32);
    auto_env = 1'b0;
  endtask

  task automatic test_invalid();
    bit ok = 1;
    do_reset();
    @(negedge clk); core_sel = 0; batch = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(done == 1 && busy == 0 && key_wr == 0, "R8 immediate done", {busy, done, key_wr}, 3'b010);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (done || busy || key_wr || l1_req != 0 || ctl_vec != {3{7'h4D}}) ok = 0;
    end
    chk(ok, "R8 no activity", ctl_vec, {3{7'h4D}});
  endtask

  task automatic test_ignore();
    int dones = 0;
    bit ok = 1;
    do_reset();
    @(negedge clk); core_sel = 1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (8) @(negedge clk);
    core_sel = 3; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    l1_ack[0] = 1'b1;
    repeat (8) @(negedge clk);
    sta_pri[0] = 1'b0; sta_sec[0] = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (done) dones++;
      if (cv(3) != 7'h4D || l1_req[2]) ok = 0;
    end
    chk(dones == 1, "R10 one done only", dones, 1);
    chk(ok, "R10 core 3 untouched", cv(3), 7'h4D);
    chk(cv(1) == 7'h32, "R10 core 1 finished", cv(1), 7'h32);
  endtask

  initial begin
    test_reset();
    test_single();
    test_batch();
    test_invalid();
    test_ignore();
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

endmodule